// File: doc/BRIEF.md
# Pulse-Swallow Programmable Clock Divider

This block divides a fast input clock by a programmable 15-bit ratio. A modulus-16/17 prescaler runs in front of a 4-bit swallow counter and an 11-bit main counter. The prescaler is modelled in plain synchronous logic. The swallow counter holds the prescaler at 17 until it reaches zero. The main counter counts prescaler periods and ends the output cycle.

Each output cycle produces a one-clock tick for a phase comparator. A second output toggles once per output cycle, giving a square wave at half the divided rate for test observation. A new ratio is strobed in at any time and is used from the start of the next output cycle. A ratio below the legal floor is raised to the floor, so the swallow count never exceeds the main count.

Top module: `pswDivider`

## Requirements
- R1: With word W, let M = W[14:4] and A = W[3:0]. Output ticks repeat every N = 16*M + A input clocks. The prescaler counts 17 clocks per period while swallow periods remain and 16 clocks otherwise.
- R2: A strobed word below 240 is replaced by 240.
- R3: The largest word, 32767, divides by 32767.
- R4: A word strobed in the middle of an output cycle does not change that cycle. It governs every cycle from the next one on.
- R5: A word strobed on the clock edge that ends an output cycle governs the cycle that starts at that edge.
- R6: While `rst` is high, the clamped `divWord` becomes the ratio. After `rst` falls, the first tick is high in the clock period that follows the N-th rising edge.
- R7: `divTick` is high for exactly one clock per output cycle.
- R8: `halfRate` inverts on the same edge that raises `divTick` and holds its value at all other edges.
- R9: During reset, `divTick` and `halfRate` are 0.
- R10: A change on `divWord` without `loadStb` has no effect on the tick spacing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock to be divided |
| rst | input | 1 | Synchronous reset, active high |
| divWord | input | 15 | Divide ratio word: main count in bits 14:4, swallow count in bits 3:0 |
| loadStb | input | 1 | Captures divWord as the pending ratio |
| divTick | output | 1 | One-clock pulse per output cycle |
| halfRate | output | 1 | Toggles once per output cycle |

## Verification
Both outputs are registered. A tick is due in the clock period that follows the edge completing the N-th count, and `halfRate` changes at that same edge. A strobe changes nothing until the next cycle boundary. The bench keeps a behavioural model that counts edges since the last tick and holds a current ratio and a pending ratio. The model steps on each rising edge using the inputs driven at the previous falling edge. The outputs are compared with the model at every falling edge, so each result is checked in the period where it is due. Directed measures cover the first tick after reset and a strobe placed exactly on a cycle-ending edge.

// File: rtl/pswDivPkg.sv
package pswDivPkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic periodEnd;  // prescaler period completes at this edge
    logic cycleEnd;   // output cycle completes at this edge
  } ctlStrobe_t;
endpackage

// File: rtl/pswDatapath.sv
module pswDatapath
  import pswDivPkg::*;
#(
  parameter int WordW    = 15,
  parameter int SwallowW = 4,
  parameter int MinRatio = 240
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WordW-1:0] divWord,
  input  logic             loadStb,
  input  ctlStrobe_t       strobe,
  output logic             swallowLive,
  output logic             lastPeriod
);
  localparam int MainW = WordW - SwallowW;

  logic [WordW-1:0]    pendWord;
  logic [WordW-1:0]    clampWord;
  logic [WordW-1:0]    nextWord;
  logic [MainW-1:0]    mainCnt;
  logic [SwallowW-1:0] swalCnt;

  // Raise short ratios to the floor so swallow never exceeds main
  always_comb begin
    if (divWord < WordW'(MinRatio)) clampWord = WordW'(MinRatio);
    else                            clampWord = divWord;
    nextWord = loadStb ? clampWord : pendWord;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pendWord <= clampWord;
      mainCnt  <= clampWord[WordW-1:SwallowW];
      swalCnt  <= clampWord[SwallowW-1:0];
    end else begin
      pendWord <= nextWord;
      if (strobe.cycleEnd) begin
        mainCnt <= nextWord[WordW-1:SwallowW];
        swalCnt <= nextWord[SwallowW-1:0];
      end else if (strobe.periodEnd) begin
        mainCnt <= mainCnt - MainW'(1);
        if (swalCnt != '0) swalCnt <= swalCnt - SwallowW'(1);
      end
    end
  end

  assign swallowLive = (swalCnt != '0);
  assign lastPeriod  = (mainCnt == MainW'(1));
endmodule

// File: rtl/pswControl.sv
module pswControl
  import pswDivPkg::*;
#(
  parameter int SwallowW = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       swallowLive,
  input  logic       lastPeriod,
  output ctlStrobe_t strobe,
  output logic       divTick,
  output logic       halfRate
);
  localparam int PreW = SwallowW + 1;
  localparam logic [PreW-1:0] LastLong  = PreW'(2 ** SwallowW);  // modulus 2^S+1
  localparam logic [PreW-1:0] LastShort = LastLong - PreW'(1);   // modulus 2^S

  logic [PreW-1:0] preCnt;
  logic [PreW-1:0] preLast;

  always_comb begin
    preLast          = swallowLive ? LastLong : LastShort;
    strobe.periodEnd = (preCnt == preLast);
    strobe.cycleEnd  = strobe.periodEnd && lastPeriod;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      preCnt   <= '0;
      divTick  <= 1'b0;
      halfRate <= 1'b0;
    end else begin
      preCnt   <= strobe.periodEnd ? '0 : preCnt + PreW'(1);
      divTick  <= strobe.cycleEnd;
      halfRate <= halfRate ^ strobe.cycleEnd;
    end
  end
endmodule

// File: rtl/pswDivider.sv
module pswDivider
  import pswDivPkg::*;
#(
  parameter int WordW    = 15,
  parameter int SwallowW = 4,
  parameter int MinRatio = 240
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WordW-1:0] divWord,
  input  logic             loadStb,
  output logic             divTick,
  output logic             halfRate
);
  ctlStrobe_t strobe;
  logic       swallowLive;
  logic       lastPeriod;

  pswDatapath #(.WordW(WordW), .SwallowW(SwallowW), .MinRatio(MinRatio)) dp_i (
    .clk(clk), .rst(rst), .divWord(divWord), .loadStb(loadStb),
    .strobe(strobe), .swallowLive(swallowLive), .lastPeriod(lastPeriod)
  );

  pswControl #(.SwallowW(SwallowW)) ctl_i (
    .clk(clk), .rst(rst), .swallowLive(swallowLive), .lastPeriod(lastPeriod),
    .strobe(strobe), .divTick(divTick), .halfRate(halfRate)
  );
endmodule

// File: rtl/pswDivider_chk.sv
module pswDivider_chk #(
  parameter int WordW    = 15,
  parameter int MinRatio = 240
) (
  input logic clk,
  input logic rst,
  input logic divTick,
  input logic halfRate
);
  localparam int GapW = WordW + 1;
  localparam logic [GapW-1:0] MaxGap = GapW'((2 ** WordW) - 1);

  logic [GapW-1:0] gapCnt;  // edges since last tick or reset

  always_ff @(posedge clk) begin
    if (rst)          gapCnt <= '0;
    else if (divTick) gapCnt <= GapW'(1);
    else if (gapCnt != '1) gapCnt <= gapCnt + GapW'(1);
  end

  // R9: outputs cleared by reset
  p_reset_clear_r9: assert property (@(posedge clk) rst |=> (!divTick && !halfRate));

  // R7: tick lasts one clock
  p_tick_single_r7: assert property (@(posedge clk) disable iff (rst) divTick |=> !divTick);

  // R8: half-rate output flips with each tick and holds otherwise
  p_half_flip_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(divTick) |-> (halfRate != $past(halfRate)));
  p_half_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!divTick) |-> $stable(halfRate));

  // R1, R2, R3: tick spacing within the legal ratio range
  p_gap_range_r2: assert property (@(posedge clk) disable iff (rst)
    divTick |-> (gapCnt >= GapW'(MinRatio) && gapCnt <= MaxGap));
endmodule

bind pswDivider pswDivider_chk #(.WordW(WordW), .MinRatio(MinRatio)) chk_i (
  .clk(clk), .rst(rst), .divTick(divTick), .halfRate(halfRate)
);

// File: tb/pswDivider_tb_top.sv
`timescale 1ns/1ps
module pswDivider_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [14:0] divWord = 15'd0;
  logic        loadStb = 1'b0;
  logic        divTick;
  logic        halfRate;

  int checks = 0;
  int errors = 0;
  string phase = "R9";
  bit    done = 1'b0;

  // Behavioural reference model
  int mCnt = 0, mCur = 0, mPend = 0;
  bit expTick = 0, expHalf = 0;

  always #2.5 clk = ~clk;

  pswDivider dut_i (
    .clk(clk), .rst(rst), .divWord(divWord), .loadStb(loadStb),
    .divTick(divTick), .halfRate(halfRate)
  );

  function automatic int clampRatio(int w);
    return (w < 240) ? 240 : w;
  endfunction

  always @(posedge clk) begin
    int np;
    if (rst) begin
      mPend = clampRatio(int'(divWord));
      mCur = mPend; mCnt = 0; expTick = 0; expHalf = 0;
    end else begin
      np = loadStb ? clampRatio(int'(divWord)) : mPend;
      mCnt++;
      if (mCnt == mCur) begin
        expTick = 1; expHalf = ~expHalf; mCnt = 0; mCur = np;
      end else expTick = 0;
      mPend = np;
    end
  end

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Compare against the model on every clock, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      check({phase, " divTick"}, int'(divTick), int'(expTick));
      check({phase, " halfRate"}, int'(halfRate), int'(expHalf));
    end
  end

  task automatic cycles(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic load(int w);
    divWord = 15'(w); loadStb = 1'b1;
    @(negedge clk);
    loadStb = 1'b0;
  endtask

  // Watchdog
  initial begin
    cycles(190000);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int c;
    divWord = 15'(16 * 20 + 5);  // M=20, A=5, N=325
    cycles(3);
    phase = "R9";
    check("R9 reset divTick", int'(divTick), 0);
    check("R9 reset halfRate", int'(halfRate), 0);
    rst = 1'b0;
    // R6: first tick after exactly N edges
    c = 0;
    do begin @(negedge clk); c++; end while (!divTick && c < 400);
    check("R6 first tick delay", c, 325);
    phase = "R1";
    cycles(3 * 325);
    // R4: mid-cycle load of M=15, A=15 (N=255)
    phase = "R4";
    cycles(100);
    load(16 * 15 + 15);
    cycles(4 * 325);
    // R2: short word clamped
    phase = "R2";
    load(100);
    cycles(4 * 255);
    // R10: word changes without strobe
    phase = "R10";
    divWord = 15'd500;
    cycles(3 * 240);
    // R5: strobe on the edge that ends the cycle
    phase = "R5";
    while (mCnt != mCur - 1) @(negedge clk);
    load(16 * 30 + 0);  // N=480, A=0
    c = 0;
    do begin @(negedge clk); c++; end while (!divTick && c < 600);
    check("R5 boundary strobe next gap", c, 480);
    // R1: another pattern, A nonzero and M large
    phase = "R1";
    load(16 * 100 + 9);  // N=1609
    cycles(3 * 1609);
    // R3: maximum ratio
    phase = "R3";
    load(32767);
    cycles(32767 * 2 + 2000);
    // R2: exact floor
    phase = "R2";
    load(240);
    cycles(32767 + 3 * 240);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule